// File: doc/BRIEF.md
# Wait-State Register-Bank Bus Subordinate

This block is a subordinate on an AHB-style pipelined bus that holds a small bank of word-wide registers. Each transfer has two phases. The address phase is sampled at a clock edge, and its write flag, register index, low address bits and size are stored. In the following data phase, the block either takes the write data or presents the read data. The stored control, not whatever is on the bus by then, decides which register and which byte lanes a write touches.

The `WAIT_CYCLES` parameter sets how many cycles the block stretches every data phase. With a value of zero the block is a fast target, and a transfer takes the minimum two cycles. With a nonzero value it is a slow target. In that case write data is committed only in the final, ready-high cycle, and anything on the write-data input during the stall cycles is ignored. Bursts are handled as independent beats. The response is always OKAY.

Top module: `ahb_wait_regfile`

## Requirements
- R1: After reset, `readyout_o` is 1, `rdata_o` is 0 and every register reads back as 0.
- R2: An address phase is taken only when `sel_i`=1, `ready_i`=1 and `trans_i` is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00), BUSY (2'b01) or an unselected cycle changes no register and leaves `readyout_o` high in the next cycle.
- R3: Write data is taken from `wdata_i` in the data phase that follows the address phase. It is steered by the register index (`addr_i[4:2]`), the low address bits and the size stored at the address phase. Bus values present during the data phase are not used.
- R4: In every data phase, `readyout_o` is low for exactly `WAIT_CYCLES` cycles and then high for one cycle. With `WAIT_CYCLES`=0 it is high in the first data-phase cycle.
- R5: A register changes only at the edge that ends a write data phase. Values on `wdata_i` during stall cycles have no effect.
- R6: Size code 0 (byte) writes only lane `addr[1:0]`, meaning bits `8*addr[1:0]+7 : 8*addr[1:0]`.
- R7: Size code 1 (halfword) writes lanes 3:2 when `addr[1]`=1 and lanes 1:0 when `addr[1]`=0.
- R8: Size code 2 (word) writes all four lanes. Size codes above 2 are treated as word.
- R9: A read returns the addressed register on `rdata_o` in the data-phase cycle where `readyout_o` is high, after the same number of stall cycles as a write. At every other time `rdata_o` is 0.
- R10: `resp_o` is always 0 (OKAY).
- R11: A new address phase may be presented in the final cycle of a data phase. A read issued right behind a write to the same register returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Subordinate select from the decoder |
| addr_i | input | ADDR_W (5) | Byte address within the bank |
| write_i | input | 1 | 1 = write transfer, 0 = read |
| size_i | input | 3 | Transfer size code: 0 byte, 1 halfword, 2 word |
| trans_i | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| wdata_i | input | DATA_W (32) | Write data, valid in the data phase |
| ready_i | input | 1 | Bus-wide ready: the previous data phase is finishing |
| readyout_o | output | 1 | This block's ready; low stalls the data phase |
| rdata_o | output | DATA_W (32) | Read data, valid when readyout_o is high |
| resp_o | output | 1 | Response, always OKAY (0) |

## Verification
The embedded properties watch several things on every cycle. They check that the stored control stays unchanged while the data phase is stalled, and that the stall counter stays within range. They check that the first data-phase cycle is a stall on a slow target and a completion on a fast one, and that no register moves unless a write commits. They also check that a non-transfer cycle leaves the block ready, that read data stays zero outside completion, and that the lane mask has the right number of lanes for each size. Only the directed scenarios can show what each register actually holds. These include which byte lanes a byte or halfword write leaves alone, that junk on the write-data and address inputs during stalls is discarded, and that a read issued immediately after a write returns the fresh value.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] SZ_BYTE = 3'd0;
    localparam logic [2:0] SZ_HALF = 3'd1;
    localparam logic [2:0] SZ_WORD = 3'd2;

    // A transfer that carries a beat (as opposed to an idle or paused slot)
    function automatic logic carries_beat(input logic [1:0] t);
        return (t == TR_NONSEQ) || (t == TR_SEQ);
    endfunction

endpackage

// File: rtl/ahbw_addr_stage.sv
// Stores the address-phase control so the data phase can use it later.
module ahbw_addr_stage #(
    parameter int IDX_W = 3,
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             done_i,
    input  logic             write_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [2:0]       size_i,
    output logic             pend_o,
    output logic             wr_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [OFF_W-1:0] off_o,
    output logic [2:0]       size_o
);

    typedef struct packed {
        logic             pend;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
        logic [2:0]       size;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (done_i) begin
            ctl_d.pend = 1'b0;
        end
        if (accept_i) begin
            ctl_d.pend = 1'b1;
            ctl_d.wr   = write_i;
            ctl_d.idx  = idx_i;
            ctl_d.off  = off_i;
            ctl_d.size = size_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pend_o = ctl_q.pend;
    assign wr_o   = ctl_q.wr;
    assign idx_o  = ctl_q.idx;
    assign off_o  = ctl_q.off;
    assign size_o = ctl_q.size;

    // While a data phase is stalled, the stored control must not move
    assert_ctl_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pend && !done_i) |=> (ctl_q.pend && $stable(ctl_q)));

endmodule

// File: rtl/ahbw_wait_timer.sv
// Counts the stall cycles of each data phase.
module ahbw_wait_timer #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic pend_i,
    output logic done_o
);

    localparam int CNT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_limit;

    assign at_limit = (tmr_q.cnt == LIMIT);

    always_comb begin
        tmr_d = tmr_q;
        if (start_i) begin
            tmr_d.cnt = '0;
        end else if (pend_i && !at_limit) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done_o = pend_i && at_limit;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LIMIT);

    generate
        if (WAIT_CYCLES > 0) begin : g_slow
            assert_first_is_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
                start_i |=> !done_o);
        end else begin : g_fast
            assert_first_is_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
                start_i |=> done_o);
        end
    endgenerate

endmodule

// File: rtl/ahbw_lane_sel.sv
// Turns the stored size and low address bits into a byte-lane enable mask.
module ahbw_lane_sel #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [2:0]       size_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [LANES-1:0] mask_o
);

    logic full_width;
    assign full_width = (size_i >= 3'(OFF_W));

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(l);
            // A lane is inside the access when it shares the aligned group with the offset
            assign mask_o[l] = full_width ? 1'b1
                                          : (((LANE_ID ^ off_i) >> size_i) == '0);
        end
    endgenerate

endmodule

// File: rtl/ahbw_reg_bank.sv
// Word registers with per-lane write enables.
module ahbw_reg_bank #(
    parameter int NREGS  = 8,
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [NREGS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            for (int b = 0; b < LANES; b++) begin
                if (mask_i[b]) begin
                    bank_d.regs[widx_i][b*8 +: 8] = wdata_i[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata_o = bank_q.regs[ridx_i];

    assert_no_stray_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(bank_q.regs));

endmodule

// File: rtl/ahb_wait_regfile.sv
module ahb_wait_regfile
    import ahbw_pkg::*;
#(
    parameter int NREGS       = 8,
    parameter int DATA_W      = 32,
    parameter int WAIT_CYCLES = 2,
    parameter int ADDR_W      = $clog2(NREGS) + $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic [2:0]        size_i,
    input  logic [1:0]        trans_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ready_i,
    output logic              readyout_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              resp_o
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int IDX_W = $clog2(NREGS);

    logic             accept;
    logic             pend, wr, done;
    logic [IDX_W-1:0] idx_q;
    logic [OFF_W-1:0] off_q;
    logic [2:0]       size_q;
    logic [LANES-1:0] lane_mask;
    logic [DATA_W-1:0] bank_rd;

    assign accept = sel_i && ready_i && carries_beat(trans_i);

    ahbw_addr_stage #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .done_i   (done),
        .write_i  (write_i),
        .idx_i    (addr_i[OFF_W +: IDX_W]),
        .off_i    (addr_i[OFF_W-1:0]),
        .size_i   (size_i),
        .pend_o   (pend),
        .wr_o     (wr),
        .idx_o    (idx_q),
        .off_o    (off_q),
        .size_o   (size_q)
    );

    ahbw_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .pend_i  (pend),
        .done_o  (done)
    );

    ahbw_lane_sel #(.LANES(LANES), .OFF_W(OFF_W)) u_lanes (
        .size_i (size_q),
        .off_i  (off_q),
        .mask_o (lane_mask)
    );

    ahbw_reg_bank #(.NREGS(NREGS), .DATA_W(DATA_W), .LANES(LANES), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (done && wr),
        .widx_i  (idx_q),
        .mask_i  (lane_mask),
        .wdata_i (wdata_i),
        .ridx_i  (idx_q),
        .rdata_o (bank_rd)
    );

    assign readyout_o = !pend || done;
    assign rdata_o    = (done && !wr) ? bank_rd : '0;
    assign resp_o     = 1'b0;

    // A ready cycle with no accepted beat leaves the next cycle ready as well
    assert_idle_zero_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (readyout_o && !accept) |=> readyout_o);

    assert_rdata_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !readyout_o |-> (rdata_o == '0));

    assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && size_q == SZ_BYTE) |-> ($countones(lane_mask) == 1));

    assert_half_two_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && size_q == SZ_HALF) |-> ($countones(lane_mask) == 2));

    assert_word_all_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && size_q >= SZ_WORD) |-> (&lane_mask));

endmodule

// File: tb/ahb_wait_regfile_tb.sv
module ahb_wait_regfile_tb;

    localparam int CLK_P = 10;
    localparam int WAITS = 2;
    localparam int NR    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, fsel = 1'b0;
    logic [4:0]  addr = '0;
    logic        write = 1'b0;
    logic [2:0]  size = '0;
    logic [1:0]  trans = 2'b00;
    logic [31:0] wdata = '0;
    logic        s_rdy, f_rdy, s_resp, f_resp;
    logic [31:0] s_rdata, f_rdata;

    logic [31:0] mdl [NR];
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    ahb_wait_regfile #(.NREGS(NR), .DATA_W(32), .WAIT_CYCLES(WAITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_i(addr), .write_i(write),
        .size_i(size), .trans_i(trans), .wdata_i(wdata), .ready_i(s_rdy),
        .readyout_o(s_rdy), .rdata_o(s_rdata), .resp_o(s_resp));

    ahb_wait_regfile #(.NREGS(NR), .DATA_W(32), .WAIT_CYCLES(0)) u_dut_fast (
        .clk(clk), .rst_n(rst_n), .sel_i(fsel), .addr_i(addr), .write_i(write),
        .size_i(size), .trans_i(trans), .wdata_i(wdata), .ready_i(f_rdy),
        .readyout_o(f_rdy), .rdata_o(f_rdata), .resp_o(f_resp));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_cycle;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] lanes_of(input logic [4:0] a, input logic [2:0] sz);
        if (sz == 3'd0)      return 4'b0001 << a[1:0];
        else if (sz == 3'd1) return a[1] ? 4'b1100 : 4'b0011;
        else                 return 4'b1111;
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [2:0] sz, input logic [31:0] d);
        logic [3:0] m = lanes_of(a, sz);
        for (int b = 0; b < 4; b++)
            if (m[b]) mdl[a[4:2]][b*8 +: 8] = d[b*8 +: 8];
    endtask

    function automatic logic cur_rdy(input logic fast);
        return fast ? f_rdy : s_rdy;
    endfunction

    task automatic bus_idle;
        sel = 1'b0; fsel = 1'b0; trans = 2'b00; write = 1'b0; size = 3'd0;
    endtask

    task automatic addr_phase(input logic fast, input logic wr, input logic [4:0] a, input logic [2:0] sz);
        sel = !fast; fsel = fast; trans = 2'b10; write = wr; addr = a; size = sz;
    endtask

    // Entered and left just after a rising edge with the bus idle
    task automatic do_write(input logic fast, input logic [4:0] a, input logic [2:0] sz,
                            input logic [31:0] d, output int waits);
        addr_phase(fast, 1'b1, a, sz);
        next_cycle();
        bus_idle();
        addr = ~a; size = 3'd2;            // junk control on the bus during data phase
        waits = 0;
        wdata = d ^ 32'h5A5A_5A5A;
        #1;
        while (cur_rdy(fast) !== 1'b1 && waits < 20) begin
            waits++;
            next_cycle();
            wdata = ~d;                    // junk data during stall cycles
            #1;
        end
        check("R10 resp on write", {31'd0, fast ? f_resp : s_resp}, 32'd0);
        wdata = d;
        next_cycle();
        wdata = 32'h0;
        model_write(a, sz, d);
    endtask

    task automatic do_read(input logic fast, input logic [4:0] a,
                           output logic [31:0] d, output int waits);
        addr_phase(fast, 1'b0, a, 3'd2);
        next_cycle();
        bus_idle();
        waits = 0;
        #1;
        while (cur_rdy(fast) !== 1'b1 && waits < 20) begin
            check("R9 rdata zero while stalled", fast ? f_rdata : s_rdata, 32'd0);
            waits++;
            next_cycle();
            #1;
        end
        d = fast ? f_rdata : s_rdata;
        next_cycle();
    endtask

    task automatic read_check(input logic fast, input logic [4:0] a, input string req);
        logic [31:0] d;
        int w;
        do_read(fast, a, d, w);
        check(req, d, mdl[a[4:2]]);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        int w;
        check("R1 readyout after reset", {31'd0, s_rdy}, 32'd1);
        check("R1 rdata after reset", s_rdata, 32'd0);
        check("R1 fast readyout after reset", {31'd0, f_rdy}, 32'd1);
        for (int r = 0; r < NR; r++) begin
            do_read(1'b0, 5'(r*4), d, w);
            check("R1 register zero after reset", d, 32'd0);
        end
    endtask

    task automatic t_word_slow;
        int w;
        do_write(1'b0, 5'h0C, 3'd2, 32'hA5A5_1234, w);
        check("R4 slow write stall count", w, WAITS);
        read_check(1'b0, 5'h0C, "R8 R5 R3 word write held latched target");
        read_check(1'b0, 5'h10, "R3 junk bus address not written");
    endtask

    task automatic t_bytes;
        int w;
        do_write(1'b0, 5'h04, 3'd2, 32'hFFFF_FFFF, w);
        for (int l = 0; l < 4; l++) begin
            do_write(1'b0, 5'(4 + l), 3'd0, {4{8'(8'h10 + l)}}, w);
            read_check(1'b0, 5'h04, "R6 byte write single lane");
        end
    endtask

    task automatic t_half;
        int w;
        do_write(1'b0, 5'h08, 3'd2, 32'h1122_3344, w);
        do_write(1'b0, 5'h0A, 3'd1, 32'hAAAA_BBBB, w);
        read_check(1'b0, 5'h08, "R7 halfword upper pair");
        check("R7 halfword upper value", mdl[2], 32'hAAAA_3344);
        do_write(1'b0, 5'h08, 3'd1, 32'hCCCC_DDDD, w);
        read_check(1'b0, 5'h08, "R7 halfword lower pair");
    endtask

    task automatic t_size_big;
        int w;
        do_write(1'b0, 5'h11, 3'd3, 32'h0BAD_CAFE, w);
        read_check(1'b0, 5'h10, "R8 size above word treated as word");
    endtask

    task automatic t_ignored;
        int w;
        do_write(1'b0, 5'h14, 3'd2, 32'h7777_7777, w);
        // IDLE with select and write flag
        sel = 1'b1; trans = 2'b00; write = 1'b1; addr = 5'h14; size = 3'd2; wdata = 32'h0;
        next_cycle();
        wdata = 32'h0;
        #1;
        check("R2 idle gives zero-wait", {31'd0, s_rdy}, 32'd1);
        // BUSY
        trans = 2'b01;
        next_cycle();
        #1;
        check("R2 busy gives zero-wait", {31'd0, s_rdy}, 32'd1);
        // NONSEQ but unselected
        sel = 1'b0; trans = 2'b10;
        next_cycle();
        #1;
        check("R2 unselected gives zero-wait", {31'd0, s_rdy}, 32'd1);
        bus_idle();
        next_cycle();
        read_check(1'b0, 5'h14, "R2 ignored slots leave register unchanged");
    endtask

    task automatic t_fast;
        logic [31:0] d;
        int w;
        do_write(1'b1, 5'h18, 3'd2, 32'h1357_9BDF, w);
        check("R4 fast write has no stall", w, 0);
        do_read(1'b1, 5'h18, d, w);
        check("R9 fast read has no stall", w, 0);
        check("R9 fast read value", d, 32'h1357_9BDF);
    endtask

    task automatic t_b2b;
        logic [31:0] d;
        int w;
        addr_phase(1'b0, 1'b1, 5'h1C, 3'd2);
        next_cycle();
        bus_idle();
        w = 0;
        wdata = 32'h0;
        #1;
        while (s_rdy !== 1'b1 && w < 20) begin
            w++;
            next_cycle();
            #1;
        end
        check("R11 write stall before overlap", w, WAITS);
        // final data cycle of the write doubles as the read's address phase
        wdata = 32'hCAFE_F00D;
        addr_phase(1'b0, 1'b0, 5'h1C, 3'd2);
        next_cycle();
        bus_idle();
        model_write(5'h1C, 3'd2, 32'hCAFE_F00D);
        w = 0;
        #1;
        check("R11 read stalls after overlap", {31'd0, s_rdy}, 32'd0);
        while (s_rdy !== 1'b1 && w < 20) begin
            w++;
            next_cycle();
            #1;
        end
        d = s_rdata;
        check("R11 pipelined read stall count", w, WAITS);
        check("R11 pipelined read sees new value", d, 32'hCAFE_F00D);
        next_cycle();
    endtask

    initial begin
        for (int r = 0; r < NR; r++) mdl[r] = 32'd0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        next_cycle();
        t_reset();
        t_word_slow();
        t_bytes();
        t_half();
        t_size_big();
        t_ignored();
        t_fast();
        t_b2b();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule